// File: doc/BRIEF.md
# Rotate and Shift Unit with Flags

This block performs one single-operand rotate or shift on a 32-bit value each time a request is accepted. Seven operations are available: plain rotates left and right, rotates that pass through the carry flag as a 33rd bit, a logical left shift, a logical right shift and an arithmetic right shift. Along with the result, it returns the values of the carry, overflow, sign, zero and parity flags, each with its own update enable. A consumer uses the enables to decide which flags and whether the destination operand get written back.

The shift count comes from one of three sources picked per request: a fixed 1, an immediate byte or a count-register byte. Only the low five bits of the immediate or register count are used. A count of zero turns the operation into a no-op: no write and no flag update.

Requests arrive on a valid/ready interface. The output side is a single registered stage with its own valid/ready pair. A request is accepted when `in_valid` and `in_ready` are both high. Its outputs appear on the next cycle with `out_valid` high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, every output holds and no new request is taken.

Top module: `rsu_unit`

## Requirements
- R1: Count select `in_cnt_sel` picks the count: 2'b00 gives 1, 2'b01 gives `in_imm[4:0]`, 2'b10 and 2'b11 give `in_creg[4:0]`. Upper bits of the immediate and the register are ignored.
- R2: With a count of zero, `out_result` equals the operand, and `out_result_we` and all five flag enables are 0.
- R3: Op 3'b000 rotates left and sets CF to result bit 0. Op 3'b001 rotates right and sets CF to result bit 31.
- R4: For the four rotate ops (3'b000 to 3'b011), only CF is updated for any nonzero count. OF is also updated when the count is 1, and then equals operand bit 31 XOR result bit 31. SF, ZF and PF enables stay 0.
- R5: Op 3'b010 rotates the 33-bit value {CF, operand} left by n. The low 32 bits form the result, and CF becomes operand bit 32-n.
- R6: Op 3'b011 rotates {CF, operand} right by n. The low 32 bits form the result, and CF becomes operand bit n-1.
- R7: Ops 3'b100 and 3'b110 shift left and fill with zeros. CF becomes operand bit 32-n. At count 1, OF is result bit 31 XOR the new CF.
- R8: Op 3'b101 shifts right and fills with zeros. CF becomes operand bit n-1. At count 1, OF is operand bit 31.
- R9: Op 3'b111 shifts right and fills with copies of operand bit 31. CF becomes operand bit n-1. At count 1, OF is 0.
- R10: The three shifts update CF, SF, ZF and PF for any nonzero count. SF is result bit 31, ZF is high for a zero result, and PF is high when result bits 7:0 hold an even number of ones. Any flag whose enable is 0 is output as 0.
- R11: A request accepted in one cycle shows its outputs with `out_valid` high in the next cycle. `in_ready` is high when `out_valid` is low or `out_ready` is high. Outputs hold while `out_valid` is high and `out_ready` is low.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_op | input | 3 | Operation code |
| in_cnt_sel | input | 2 | Count source select |
| in_imm | input | 8 | Immediate count byte |
| in_creg | input | 8 | Count register byte |
| in_operand | input | 32 | Value to rotate or shift |
| in_cf | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Rotated or shifted value |
| out_result_we | output | 1 | Result write enable |
| out_cf | output | 1 | Carry flag value |
| out_cf_we | output | 1 | Carry flag update enable |
| out_of | output | 1 | Overflow flag value |
| out_of_we | output | 1 | Overflow flag update enable |
| out_sf | output | 1 | Sign flag value |
| out_sf_we | output | 1 | Sign flag update enable |
| out_zf | output | 1 | Zero flag value |
| out_zf_we | output | 1 | Zero flag update enable |
| out_pf | output | 1 | Parity flag value |
| out_pf_we | output | 1 | Parity flag update enable |

## Verification
The bench sweeps every op code over every count 0 to 31, with several operands and both carry-in values. It compares the result against a bit-at-a-time reference, so an off-by-one in the 33-bit carry rotation shows up as a displaced carry bit or a wrong CF. Count 1 and count 0 are the sharp corners: a design that drops the OF enable or leaves flag enables on at count zero would corrupt the flags of a no-op. Masking is tested with junk in the upper count bits, which a design that used the full byte would turn into an oversized shift. A stall with a second request waiting checks that the held output does not change and that the waiting request is not lost.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic [2:0] {
    OP_ROL     = 3'b000,
    OP_ROR     = 3'b001,
    OP_RCL     = 3'b010,
    OP_RCR     = 3'b011,
    OP_SHL     = 3'b100,
    OP_SHR     = 3'b101,
    OP_SHL_ALT = 3'b110,
    OP_SAR     = 3'b111
  } rsu_op_e;

  typedef enum logic [1:0] {
    CSRC_ONE     = 2'b00,
    CSRC_IMM     = 2'b01,
    CSRC_REG     = 2'b10,
    CSRC_REG_ALT = 2'b11
  } rsu_csrc_e;

  typedef struct packed {
    logic cf;
    logic cf_we;
    logic of;
    logic of_we;
    logic sf;
    logic sf_we;
    logic zf;
    logic zf_we;
    logic pf;
    logic pf_we;
  } rsu_flags_t;
endpackage

// File: rtl/rsu_count_sel.sv
module rsu_count_sel #(
  parameter int CW     = 5,
  parameter int IMM_W  = 8,
  parameter int CREG_W = 8
) (
  input  logic [1:0]        sel,
  input  logic [IMM_W-1:0]  imm,
  input  logic [CREG_W-1:0] creg,
  output logic [CW-1:0]     cnt
);
  import rsu_pkg::*;

  always_comb begin
    unique case (rsu_csrc_e'(sel))
      CSRC_ONE: cnt = CW'(1);
      CSRC_IMM: cnt = imm[CW-1:0];
      default:  cnt = creg[CW-1:0];
    endcase
  end
endmodule

// File: rtl/rsu_rotator.sv
module rsu_rotator #(
  parameter int WIDTH = 32,
  parameter int CW    = 5
) (
  input  logic             thru_carry,
  input  logic             go_right,
  input  logic [WIDTH-1:0] operand,
  input  logic             cf_in,
  input  logic [CW-1:0]    cnt,
  output logic [WIDTH-1:0] result,
  output logic             cf_out
);
  localparam int XW = WIDTH + 1;

  logic [XW-1:0]      ext;
  logic [2*XW-1:0]    ext_l, ext_r;
  logic [XW-1:0]      ext_rot;
  logic [2*WIDTH-1:0] pl_l, pl_r;
  logic [WIDTH-1:0]   pl_rot;

  assign ext   = {cf_in, operand};
  assign ext_l = {ext, ext} << cnt;
  assign ext_r = {ext, ext} >> cnt;
  assign pl_l  = {operand, operand} << cnt;
  assign pl_r  = {operand, operand} >> cnt;

  assign ext_rot = go_right ? ext_r[XW-1:0] : ext_l[2*XW-1:XW];
  assign pl_rot  = go_right ? pl_r[WIDTH-1:0] : pl_l[2*WIDTH-1:WIDTH];

  always_comb begin
    if (thru_carry) begin
      result = ext_rot[WIDTH-1:0];
      cf_out = ext_rot[WIDTH];
    end else begin
      result = pl_rot;
      cf_out = go_right ? pl_rot[WIDTH-1] : pl_rot[0];
    end
  end
endmodule

// File: rtl/rsu_shifter.sv
module rsu_shifter #(
  parameter int WIDTH = 32,
  parameter int CW    = 5
) (
  input  logic             go_right,
  input  logic             arith,
  input  logic [WIDTH-1:0] operand,
  input  logic [CW-1:0]    cnt,
  output logic [WIDTH-1:0] result,
  output logic             cf_out
);
  logic [WIDTH:0] left_t;
  logic [WIDTH:0] right_t;

  assign left_t = {1'b0, operand} << cnt;

  always_comb begin
    if (arith) right_t = $unsigned($signed({operand, 1'b0}) >>> cnt);
    else       right_t = {operand, 1'b0} >> cnt;
  end

  assign result = go_right ? right_t[WIDTH:1] : left_t[WIDTH-1:0];
  assign cf_out = go_right ? right_t[0] : left_t[WIDTH];
endmodule

// File: rtl/rsu_flags.sv
module rsu_flags #(
  parameter int WIDTH = 32
) (
  input  logic [2:0]          op,
  input  logic                cnt_zero,
  input  logic                cnt_one,
  input  logic [WIDTH-1:0]    operand,
  input  logic [WIDTH-1:0]    result,
  input  logic                cf_new,
  output rsu_pkg::rsu_flags_t flags
);
  import rsu_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic is_shift;
  logic of_val;

  assign is_shift = op[2];

  always_comb begin
    unique case (rsu_op_e'(op))
      OP_SHL, OP_SHL_ALT: of_val = result[MSB] ^ cf_new;
      OP_SHR:             of_val = operand[MSB];
      OP_SAR:             of_val = 1'b0;
      default:            of_val = operand[MSB] ^ result[MSB];
    endcase
  end

  always_comb begin
    flags = '0;
    if (!cnt_zero) begin
      flags.cf_we = 1'b1;
      flags.cf    = cf_new;
      flags.of_we = cnt_one;
      flags.of    = cnt_one & of_val;
      flags.sf_we = is_shift;
      flags.sf    = is_shift & result[MSB];
      flags.zf_we = is_shift;
      flags.zf    = is_shift & (result == '0);
      flags.pf_we = is_shift;
      flags.pf    = is_shift & ~(^result[7:0]);
    end
  end
endmodule

// File: rtl/rsu_unit.sv
module rsu_unit #(
  parameter int WIDTH  = 32,
  parameter int IMM_W  = 8,
  parameter int CREG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [1:0]        in_cnt_sel,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [CREG_W-1:0] in_creg,
  input  logic [WIDTH-1:0]  in_operand,
  input  logic              in_cf,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDTH-1:0]  out_result,
  output logic              out_result_we,
  output logic              out_cf,
  output logic              out_cf_we,
  output logic              out_of,
  output logic              out_of_we,
  output logic              out_sf,
  output logic              out_sf_we,
  output logic              out_zf,
  output logic              out_zf_we,
  output logic              out_pf,
  output logic              out_pf_we
);
  import rsu_pkg::*;

  localparam int CW = $clog2(WIDTH);

  logic [CW-1:0]    cnt;
  logic             cnt_zero, cnt_one;
  logic [WIDTH-1:0] rot_res, shf_res, sel_res, nxt_res;
  logic             rot_cf, shf_cf, sel_cf;
  rsu_flags_t       nxt_flags;
  rsu_flags_t       flags_q;
  logic [WIDTH-1:0] res_q;
  logic             we_q;
  logic             valid_q;
  logic             accept;

  rsu_count_sel #(.CW(CW), .IMM_W(IMM_W), .CREG_W(CREG_W)) u_cnt (
    .sel  (in_cnt_sel),
    .imm  (in_imm),
    .creg (in_creg),
    .cnt  (cnt)
  );

  assign cnt_zero = (cnt == '0);
  assign cnt_one  = (cnt == CW'(1));

  rsu_rotator #(.WIDTH(WIDTH), .CW(CW)) u_rot (
    .thru_carry (in_op[1]),
    .go_right   (in_op[0]),
    .operand    (in_operand),
    .cf_in      (in_cf),
    .cnt        (cnt),
    .result     (rot_res),
    .cf_out     (rot_cf)
  );

  rsu_shifter #(.WIDTH(WIDTH), .CW(CW)) u_shf (
    .go_right (in_op == OP_SHR || in_op == OP_SAR),
    .arith    (in_op == OP_SAR),
    .operand  (in_operand),
    .cnt      (cnt),
    .result   (shf_res),
    .cf_out   (shf_cf)
  );

  assign sel_res = in_op[2] ? shf_res : rot_res;
  assign sel_cf  = in_op[2] ? shf_cf  : rot_cf;
  assign nxt_res = cnt_zero ? in_operand : sel_res;

  rsu_flags #(.WIDTH(WIDTH)) u_flg (
    .op       (in_op),
    .cnt_zero (cnt_zero),
    .cnt_one  (cnt_one),
    .operand  (in_operand),
    .result   (sel_res),
    .cf_new   (sel_cf),
    .flags    (nxt_flags)
  );

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      we_q    <= 1'b0;
      flags_q <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      res_q   <= nxt_res;
      we_q    <= !cnt_zero;
      flags_q <= nxt_flags;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid     = valid_q;
  assign out_result    = res_q;
  assign out_result_we = we_q;
  assign out_cf        = flags_q.cf;
  assign out_cf_we     = flags_q.cf_we;
  assign out_of        = flags_q.of;
  assign out_of_we     = flags_q.of_we;
  assign out_sf        = flags_q.sf;
  assign out_sf_we     = flags_q.sf_we;
  assign out_zf        = flags_q.zf;
  assign out_zf_we     = flags_q.zf_we;
  assign out_pf        = flags_q.pf;
  assign out_pf_we     = flags_q.pf_we;
endmodule

// File: rtl/rsu_unit_chk.sv
module rsu_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic             out_result_we,
  input logic             out_cf,
  input logic             out_cf_we,
  input logic             out_of,
  input logic             out_of_we,
  input logic             out_sf,
  input logic             out_sf_we,
  input logic             out_zf,
  input logic             out_zf_we,
  input logic             out_pf,
  input logic             out_pf_we
);
  logic [2:0] held_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    held_op <= 3'b000;
    else if (in_valid && in_ready) held_op <= in_op;
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R11

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_result_we) && $stable(out_cf) && $stable(out_cf_we))); // R11

  AST_NOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_result_we) |->
      !(out_cf_we || out_of_we || out_sf_we || out_zf_we || out_pf_we)); // R2

  AST_OFF_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !((out_cf && !out_cf_we) || (out_of && !out_of_we) ||
      (out_sf && !out_sf_we) || (out_zf && !out_zf_we) || (out_pf && !out_pf_we))); // R10

  AST_OF_WITH_CF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_of_we) |-> out_cf_we); // R4

  AST_ROT_NO_SZP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !held_op[2]) |-> !(out_sf_we || out_zf_we || out_pf_we)); // R4
endmodule

bind rsu_unit rsu_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/rsu_unit_tb.sv
module rsu_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [1:0]  in_cnt_sel = 2'd0;
  logic [7:0]  in_imm = 8'd0;
  logic [7:0]  in_creg = 8'd0;
  logic [31:0] in_operand = 32'd0;
  logic        in_cf = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_result_we;
  logic        out_cf, out_cf_we, out_of, out_of_we, out_sf, out_sf_we;
  logic        out_zf, out_zf_we, out_pf, out_pf_we;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rsu_unit u_dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_op, .in_cnt_sel, .in_imm,
    .in_creg, .in_operand, .in_cf, .out_valid, .out_ready, .out_result,
    .out_result_we, .out_cf, .out_cf_we, .out_of, .out_of_we, .out_sf,
    .out_sf_we, .out_zf, .out_zf_we, .out_pf, .out_pf_we
  );

  function automatic logic [42:0] got_vec();
    return {out_result, out_result_we, out_cf, out_cf_we, out_of, out_of_we,
            out_sf, out_sf_we, out_zf, out_zf_we, out_pf, out_pf_we};
  endfunction

  function automatic int pick_count(logic [1:0] sel, logic [7:0] imm, logic [7:0] creg);
    if (sel == 2'b00) return 1;
    if (sel == 2'b01) return int'(imm[4:0]);
    return int'(creg[4:0]);
  endfunction

  // Bit-at-a-time reference: {result, we, cf,cfwe, of,ofwe, sf,sfwe, zf,zfwe, pf,pfwe}
  function automatic logic [42:0] model(logic [2:0] op, int n, logic [31:0] a, logic c);
    logic [31:0] v = a;
    logic cy = c;
    logic nc;
    logic cf = 0, of = 0, sf = 0, zf = 0, pf = 0;
    logic ofw = 0, szp = 0;
    if (n == 0) return {a, 11'b0};
    for (int i = 0; i < n; i++) begin
      case (op)
        3'd0: v = {v[30:0], v[31]};
        3'd1: v = {v[0], v[31:1]};
        3'd2: begin nc = v[31]; v = {v[30:0], cy}; cy = nc; end
        3'd3: begin nc = v[0]; v = {cy, v[31:1]}; cy = nc; end
        3'd5: begin cy = v[0]; v = {1'b0, v[31:1]}; end
        3'd7: begin cy = v[0]; v = {v[31], v[31:1]}; end
        default: begin cy = v[31]; v = {v[30:0], 1'b0}; end
      endcase
    end
    case (op)
      3'd0: cf = v[0];
      3'd1: cf = v[31];
      default: cf = cy;
    endcase
    ofw = (n == 1);
    if (ofw) begin
      case (op)
        3'd4, 3'd6: of = v[31] ^ cf;
        3'd5: of = a[31];
        3'd7: of = 1'b0;
        default: of = a[31] ^ v[31];
      endcase
    end
    szp = op[2];
    if (szp) begin
      sf = v[31];
      zf = (v == 32'd0);
      pf = ~(^v[7:0]);
    end
    return {v, 1'b1, cf, 1'b1, of, ofw, sf, szp, zf, szp, pf, szp};
  endfunction

  task automatic check(string req, logic [42:0] got, logic [42:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_bit(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  // Issue one request and sample its output one cycle later.
  task automatic run(string req, logic [2:0] op, logic [1:0] sel, logic [7:0] imm,
                     logic [7:0] creg, logic [31:0] a, logic c);
    @(negedge clk);
    in_op = op; in_cnt_sel = sel; in_imm = imm; in_creg = creg;
    in_operand = a; in_cf = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit(req, out_valid, 1'b1);
    check(req, got_vec(), model(op, pick_count(sel, imm, creg), a, c));
  endtask

  function automatic string tag_for(logic [2:0] op, int n);
    if (n == 0) return "R2";
    case (op)
      3'd0, 3'd1: return (n == 1) ? "R4" : "R3";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd5: return "R8";
      3'd7: return "R9";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4] = '{32'h8000_0001, 32'h1234_5678, 32'hF0F0_0F0F, 32'h7FFF_FFFE};
    logic [42:0] held;
    repeat (3) @(negedge clk);
    // R12: idle after reset
    check_bit("R12 out_valid", out_valid, 1'b0);
    check_bit("R12 in_ready", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R12 idle", out_valid, 1'b0);

    // R1: count sources, upper bits junk
    run("R1 one", 3'd0, 2'b00, 8'hFF, 8'hFF, 32'h8000_0001, 1'b0);
    run("R1 imm", 3'd4, 2'b01, 8'hE5, 8'h03, 32'h0000_00FF, 1'b0);
    run("R1 reg", 3'd5, 2'b10, 8'h01, 8'h47, 32'hFF00_0000, 1'b0);
    run("R1 reg alt", 3'd7, 2'b11, 8'h02, 8'hA9, 32'h8000_0000, 1'b1);
    run("R2 masked zero", 3'd2, 2'b01, 8'hE0, 8'h05, 32'hDEAD_BEEF, 1'b1);

    // R10: flag-derived corners
    run("R10 zero result", 3'd4, 2'b00, 8'h0, 8'h0, 32'h8000_0000, 1'b0);
    run("R10 odd parity", 3'd5, 2'b01, 8'h08, 8'h0, 32'h0000_0100, 1'b0);
    run("R10 sign fill", 3'd7, 2'b01, 8'h1F, 8'h0, 32'h8000_0000, 1'b0);

    // Sweep: every op, every count, several operands, both carries
    for (int op = 0; op < 8; op++)
      for (int n = 0; n < 32; n++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++)
            run(tag_for(3'(op), n), 3'(op), (n[0] ? 2'b01 : 2'b10),
                8'(n) | 8'hA0, 8'(n) | 8'h60, pats[p], 1'(c));

    // R11: stall with a second request waiting
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 3'd0; in_cnt_sel = 2'b00; in_operand = 32'h8000_0001; in_cf = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    check("R11 first out", got_vec(), model(3'd0, 1, 32'h8000_0001, 1'b0));
    check_bit("R11 ready low", in_ready, 1'b0);
    held = got_vec();
    in_op = 3'd1; in_operand = 32'h0000_0002;
    repeat (2) @(negedge clk);
    check_bit("R11 still valid", out_valid, 1'b1);
    check("R11 held", got_vec(), held);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 second out", got_vec(), model(3'd1, 1, 32'h0000_0002, 1'b0));
    @(negedge clk);
    check_bit("R11 drained", out_valid, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule